// File: doc/BRIEF.md
# Byte Arithmetic Unit with Condition Register

This block is the data path of a small 8-bit processor core: it takes an operand A, an operand B and an operation code, and produces a byte result together with a condition byte. Fifteen operations are available: binary addition and subtraction, each with or without the stored carry, a decimal correction step for packed BCD, four bitwise operations, four rotates, increment and decrement. The carry, half-carry, zero and overflow flags are updated according to the operation class. Decode of instructions and access to the register file happen outside; the block sees only operands, a code and an enable.

The condition register also holds a sleep flag and a watchdog-expiry flag. These two are driven only by the HALT, CLR WDT and watchdog-timeout strobes, never by the arithmetic or by a write to the condition register. The result and the condition byte are both registered. An operation issued in one cycle is visible on the outputs after the next rising clock edge. Its carry-in comes from the flag value present when it is issued, so back-to-back operations chain correctly.

Top module: `alu8_status_unit`

## Requirements
- R1: While rst is high at a clock edge, result becomes 0x00 and status becomes 0x00. Status layout: bit0 carry C, bit1 half-carry AC, bit2 zero Z, bit3 overflow OV, bit4 sleep flag, bit5 watchdog flag, bits 7:6 always 0.
- R2: Code 0 adds A+B and code 1 adds A+B+C. C becomes the carry out of bit 7.
- R3: Code 2 computes A-B as A+~B+1, and code 3 computes A+~B+C, so a set C means no borrow is pending. C becomes 1 when no borrow occurs.
- R4: For codes 0 to 3, AC becomes the carry out of bit 3 of the same sum, which means no nibble borrow on subtraction.
- R5: For codes 0 to 3 and 5 to 8 and 13 to 14, Z becomes 1 exactly when the byte result is 0x00.
- R6: For codes 0 to 3, OV becomes the XOR of the carry into bit 7 and the carry out of bit 7.
- R7: Codes 5 AND, 6 OR, 7 XOR, 8 complement A, 13 A+1 and 14 A-1 change only Z. C, AC and OV keep their values.
- R8: Code 9 rotates A left and code 10 rotates it right, changing no flag. Code 11 rotates left through C and code 12 rotates right through C; each changes only C, which takes the bit shifted out.
- R9: Code 4 corrects A. It adds 0x06 when A[3:0] > 9 or AC=1, and adds 0x60 when A[7:4] > 9 or C=1; both decisions use the value of A before correction. C becomes 1 if the high correction applied or the sum carried out, and 0 otherwise. No other flag changes.
- R10: A status write (st_wr) loads bits 3:0 from st_wdata[3:0] and leaves bits 5:4 unchanged. If an operation is issued in the same cycle, the write decides the flags while the result still updates.
- R11: HALT sets the sleep flag and clears the watchdog flag. CLR WDT clears both and wins over HALT in the same cycle.
- R12: A watchdog timeout sets the watchdog flag unless HALT or CLR WDT arrives in the same cycle, in which case the flag is cleared. None of the three strobes changes bits 3:0.
- R13: With op_en low, or with code 15, result and bits 3:0 of status hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| op_en | input | 1 | Issue the operation on op_code this cycle |
| op_code | input | 4 | Operation code 0..15 |
| opnd_a | input | 8 | Operand A |
| opnd_b | input | 8 | Operand B |
| halt_stb | input | 1 | HALT executed |
| clrwdt_stb | input | 1 | CLR WDT executed |
| wdt_to_stb | input | 1 | Watchdog expired |
| st_wr | input | 1 | Write the condition register |
| st_wdata | input | 8 | Data for the condition register write |
| result | output | 8 | Registered result |
| status | output | 8 | Registered condition byte |

## Verification
Addition is tried on a mid-range pair that sets half-carry and signed overflow without carry, and on 0xFF+1, which sets carry, half-carry and zero but not overflow. Together these separate OV from C. Subtraction is tried on cases with and without borrow, on a signed-overflow case, and with the borrow-in chained through C. Together these show whether C is taken as the inverse of borrow. Logic, increment, decrement and rotates run with all four flags preset to 1 or to 0, which exposes any flag they must not touch. A rotate through carry that yields zero shows that Z stays put. Decimal correction is tried with each of its two triggers, nibble digit overflow and a stored flag, alone and combined. The strobes and status writes are issued alone and in conflicting pairs to pin down priority.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_DAA = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_CPL = 4'd8,
    OP_RL  = 4'd9,
    OP_RR  = 4'd10,
    OP_RLC = 4'd11,
    OP_RRC = 4'd12,
    OP_INC = 4'd13,
    OP_DEC = 4'd14,
    OP_NOP = 4'd15
  } alu_op_e;

  localparam int FL_C  = 0;
  localparam int FL_AC = 1;
  localparam int FL_Z  = 2;
  localparam int FL_OV = 3;
  localparam int FL_PD = 4;
  localparam int FL_TO = 5;
  localparam int NUM_ARITH_FLAGS = 4;

  typedef struct packed {
    logic ov_we;
    logic z_we;
    logic ac_we;
    logic c_we;
    logic ov;
    logic z;
    logic ac;
    logic c;
  } flag_upd_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW  = 8,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          ac_out,
  output logic          ov_out
);
  logic [DW-1:0]  bx;
  logic [DW:0]    full;
  logic [NIB:0]   low;
  logic [DW-1:0]  below_top;

  assign bx = sub ? ~b : b;

  always_comb begin
    full      = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, cin};
    low       = {1'b0, a[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, cin};
    below_top = {1'b0, a[DW-2:0]} + {1'b0, bx[DW-2:0]} + {{(DW-1){1'b0}}, cin};
  end

  assign sum    = full[DW-1:0];
  assign c_out  = full[DW];
  assign ac_out = low[NIB];
  assign ov_out = below_top[DW-1] ^ full[DW];
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
  parameter int DW  = 8,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] a,
  input  logic          c_in,
  input  logic          ac_in,
  output logic [DW-1:0] res,
  output logic          c_out
);
  localparam int HI_LSB = DW - NIB;
  localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);
  localparam logic [NIB-1:0] ADJ       = NIB'(6);

  logic          lo_fix, hi_fix;
  logic [DW-1:0] adj;
  logic [DW:0]   tot;

  assign lo_fix = (a[NIB-1:0] > DIGIT_MAX) | ac_in;
  assign hi_fix = (a[DW-1:HI_LSB] > DIGIT_MAX) | c_in;

  always_comb begin
    adj = '0;
    if (lo_fix) adj[NIB-1:0]     = ADJ;
    if (hi_fix) adj[DW-1:HI_LSB] = ADJ;
    tot = {1'b0, a} + {1'b0, adj};
  end

  assign res   = tot[DW-1:0];
  assign c_out = hi_fix | tot[DW];
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output logic          c_out
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    res   = '0;
    c_out = c_in;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_CPL: res = ~a;
      OP_RL:  res = {a[DW-2:0], a[DW-1]};
      OP_RR:  res = {a[0], a[DW-1:1]};
      OP_RLC: begin
        res   = {a[DW-2:0], c_in};
        c_out = a[DW-1];
      end
      OP_RRC: begin
        res   = {c_in, a[DW-1:1]};
        c_out = a[0];
      end
      OP_INC: res = a + ONE;
      OP_DEC: res = a - ONE;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
  import alu8_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  flag_upd_t     upd,
  input  logic          wr,
  input  logic [SW-1:0] wdata,
  input  logic          halt,
  input  logic          clrwdt,
  input  logic          wdt_to,
  output logic [SW-1:0] status
);
  logic c_q, ac_q, z_q, ov_q, pd_q, to_q;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[SW-1:NUM_ARITH_FLAGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q  <= 1'b0;
      ac_q <= 1'b0;
      z_q  <= 1'b0;
      ov_q <= 1'b0;
    end else if (wr) begin
      c_q  <= wdata[FL_C];
      ac_q <= wdata[FL_AC];
      z_q  <= wdata[FL_Z];
      ov_q <= wdata[FL_OV];
    end else if (upd_en) begin
      if (upd.c_we)  c_q  <= upd.c;
      if (upd.ac_we) ac_q <= upd.ac;
      if (upd.z_we)  z_q  <= upd.z;
      if (upd.ov_we) ov_q <= upd.ov;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q <= 1'b0;
      to_q <= 1'b0;
    end else begin
      if (clrwdt)    pd_q <= 1'b0;
      else if (halt) pd_q <= 1'b1;
      if (clrwdt || halt) to_q <= 1'b0;
      else if (wdt_to)    to_q <= 1'b1;
    end
  end

  always_comb begin
    status        = '0;
    status[FL_C]  = c_q;
    status[FL_AC] = ac_q;
    status[FL_Z]  = z_q;
    status[FL_OV] = ov_q;
    status[FL_PD] = pd_q;
    status[FL_TO] = to_q;
  end

  assert_wr_keeps_sys_R10: assert property (@(posedge clk) disable iff (rst)
    (wr && !halt && !clrwdt && !wdt_to) |=> status[FL_TO:FL_PD] == $past(status[FL_TO:FL_PD]))
    else $error("status write altered sleep/watchdog flags");

  assert_wr_loads_low_R10: assert property (@(posedge clk) disable iff (rst)
    wr |=> status[FL_OV:FL_C] == $past(wdata[FL_OV:FL_C]))
    else $error("status write did not load flags");

  assert_halt_sets_pd_R11: assert property (@(posedge clk) disable iff (rst)
    (halt && !clrwdt) |=> (status[FL_PD] && !status[FL_TO]))
    else $error("HALT effect wrong");

  assert_clrwdt_clears_R11: assert property (@(posedge clk) disable iff (rst)
    clrwdt |=> (!status[FL_PD] && !status[FL_TO]))
    else $error("CLR WDT effect wrong");

  assert_timeout_sets_to_R12: assert property (@(posedge clk) disable iff (rst)
    (wdt_to && !halt && !clrwdt) |=> status[FL_TO])
    else $error("timeout did not set watchdog flag");
endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
  import alu8_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NIB = 4,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_en,
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  opnd_a,
  input  logic [DW-1:0]  opnd_b,
  input  logic           halt_stb,
  input  logic           clrwdt_stb,
  input  logic           wdt_to_stb,
  input  logic           st_wr,
  input  logic [DW-1:0]  st_wdata,
  output logic [DW-1:0]  result,
  output logic [DW-1:0]  status
);
  alu_op_e       opc;
  logic          c_cur, ac_cur;
  logic          as_sub, as_cin;
  logic [DW-1:0] as_sum, daa_res, bit_res, res_d;
  logic          as_c, as_ac, as_ov, daa_c, bit_c, load;
  flag_upd_t     upd;

  assign opc    = alu_op_e'(op_code);
  assign c_cur  = status[FL_C];
  assign ac_cur = status[FL_AC];

  always_comb begin
    as_sub = (opc == OP_SUB) || (opc == OP_SBC);
    case (opc)
      OP_ADC, OP_SBC: as_cin = c_cur;
      OP_SUB:         as_cin = 1'b1;
      default:        as_cin = 1'b0;
    endcase
  end

  alu8_addsub #(.DW(DW), .NIB(NIB)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(as_sub), .cin(as_cin),
    .sum(as_sum), .c_out(as_c), .ac_out(as_ac), .ov_out(as_ov)
  );

  alu8_daa #(.DW(DW), .NIB(NIB)) u_daa (
    .a(opnd_a), .c_in(c_cur), .ac_in(ac_cur), .res(daa_res), .c_out(daa_c)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .op(opc), .a(opnd_a), .b(opnd_b), .c_in(c_cur), .res(bit_res), .c_out(bit_c)
  );

  always_comb begin
    upd   = '0;
    load  = 1'b1;
    res_d = bit_res;
    case (opc)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_d     = as_sum;
        upd.c_we  = 1'b1;
        upd.ac_we = 1'b1;
        upd.z_we  = 1'b1;
        upd.ov_we = 1'b1;
        upd.c     = as_c;
        upd.ac    = as_ac;
        upd.ov    = as_ov;
      end
      OP_DAA: begin
        res_d    = daa_res;
        upd.c_we = 1'b1;
        upd.c    = daa_c;
      end
      OP_AND, OP_OR, OP_XOR, OP_CPL, OP_INC, OP_DEC: upd.z_we = 1'b1;
      OP_RLC, OP_RRC: begin
        upd.c_we = 1'b1;
        upd.c    = bit_c;
      end
      OP_RL, OP_RR: ;
      default: load = 1'b0;
    endcase
    upd.z = (res_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)                result <= '0;
    else if (op_en && load) result <= res_d;
  end

  alu8_status_reg #(.SW(DW)) u_status (
    .clk(clk), .rst(rst), .upd_en(op_en), .upd(upd),
    .wr(st_wr), .wdata(st_wdata),
    .halt(halt_stb), .clrwdt(clrwdt_stb), .wdt_to(wdt_to_stb),
    .status(status)
  );

  assert_idle_holds_R13: assert property (@(posedge clk) disable iff (rst)
    (!op_en || op_code == OP_NOP) |=> result == $past(result))
    else $error("result changed without an operation");

  assert_plain_rotate_no_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (op_en && !st_wr && (op_code == OP_RL || op_code == OP_RR))
      |=> status[FL_OV:FL_C] == $past(status[FL_OV:FL_C]))
    else $error("plain rotate changed a flag");

  assert_logic_only_z_R7: assert property (@(posedge clk) disable iff (rst)
    (op_en && !st_wr && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR ||
                          op_code == OP_CPL || op_code == OP_INC || op_code == OP_DEC))
      |=> {status[FL_OV], status[FL_AC], status[FL_C]} ==
          $past({status[FL_OV], status[FL_AC], status[FL_C]}))
    else $error("logic/inc/dec changed C, AC or OV");

  assert_add_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (op_en && !st_wr && op_code == OP_ADD)
      |=> status[FL_C] == (({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}) > {1'b0, {DW{1'b1}}}))
    else $error("add carry wrong");
endmodule

// File: tb/alu8_status_unit_test.sv
module alu8_status_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_en = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] opnd_a = 8'h00, opnd_b = 8'h00;
  logic       halt_stb = 1'b0, clrwdt_stb = 1'b0, wdt_to_stb = 1'b0;
  logic       st_wr = 1'b0;
  logic [7:0] st_wdata = 8'h00;
  logic [7:0] result, status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  alu8_status_unit uut (
    .clk(clk), .rst(rst), .op_en(op_en), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .halt_stb(halt_stb),
    .clrwdt_stb(clrwdt_stb), .wdt_to_stb(wdt_to_stb),
    .st_wr(st_wr), .st_wdata(st_wdata), .result(result), .status(status)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    op_en = 0; st_wr = 0; halt_stb = 0; clrwdt_stb = 0; wdt_to_stb = 0;
  endtask

  task automatic cyc(input logic en, input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                     input logic wr, input logic [7:0] wd, input logic h, input logic cw, input logic t);
    @(negedge clk);
    op_en = en; op_code = op; opnd_a = a; opnd_b = b;
    st_wr = wr; st_wdata = wd; halt_stb = h; clrwdt_stb = cw; wdt_to_stb = t;
    @(negedge clk);
    idle();
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    cyc(1, op, a, b, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic set_flags(input logic [7:0] v);
    cyc(0, 4'd15, 8'h00, 8'h00, 1, v, 0, 0, 0);
  endtask

  task automatic expect_op(input string req, input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] er, input logic [7:0] es);
    run_op(op, a, b);
    chk(req, "result", result, er);
    chk(req, "status", status, es);
  endtask

  task automatic t_reset();
    chk("R1", "result after reset", result, 8'h00);
    chk("R1", "status after reset", status, 8'h00);
  endtask

  task automatic t_add();
    set_flags(8'h00);
    expect_op("R2_R4_R6", 4'd0, 8'h3A, 8'h48, 8'h82, 8'h0A);
    expect_op("R2_R5_R6", 4'd0, 8'hFF, 8'h01, 8'h00, 8'h07);
    expect_op("R2 adc", 4'd1, 8'h10, 8'h20, 8'h31, 8'h00);
  endtask

  task automatic t_sub();
    set_flags(8'h00);
    expect_op("R3_R4", 4'd2, 8'h50, 8'h20, 8'h30, 8'h03);
    expect_op("R3 borrow", 4'd2, 8'h20, 8'h50, 8'hD0, 8'h02);
    expect_op("R3_R6", 4'd2, 8'h80, 8'h01, 8'h7F, 8'h09);
    expect_op("R3 sbc c1", 4'd3, 8'h05, 8'h05, 8'h00, 8'h07);
    set_flags(8'h00);
    expect_op("R3 sbc c0", 4'd3, 8'h05, 8'h03, 8'h01, 8'h03);
  endtask

  task automatic t_logic();
    set_flags(8'h0F);
    expect_op("R7 and", 4'd5, 8'hF0, 8'h0F, 8'h00, 8'h0F);
    expect_op("R7 or",  4'd6, 8'h12, 8'h01, 8'h13, 8'h0B);
    expect_op("R7 xor", 4'd7, 8'hAA, 8'hAA, 8'h00, 8'h0F);
    expect_op("R7 cpl", 4'd8, 8'h0F, 8'h00, 8'hF0, 8'h0B);
    set_flags(8'h00);
    expect_op("R7_R5 inc", 4'd13, 8'hFF, 8'h00, 8'h00, 8'h04);
    expect_op("R7 dec",    4'd14, 8'h00, 8'h00, 8'hFF, 8'h00);
    expect_op("R5 dec",    4'd14, 8'h01, 8'h00, 8'h00, 8'h04);
  endtask

  task automatic t_rotate();
    set_flags(8'h0F);
    expect_op("R8 rl", 4'd9,  8'h81, 8'h00, 8'h03, 8'h0F);
    expect_op("R8 rr", 4'd10, 8'h81, 8'h00, 8'hC0, 8'h0F);
    set_flags(8'h00);
    expect_op("R8 rlc", 4'd11, 8'h81, 8'h00, 8'h02, 8'h01);
    expect_op("R8 rlc cin", 4'd11, 8'h40, 8'h00, 8'h81, 8'h00);
    expect_op("R8 rrc zero", 4'd12, 8'h01, 8'h00, 8'h00, 8'h01);
    expect_op("R8 rrc cin", 4'd12, 8'h00, 8'h00, 8'h80, 8'h00);
  endtask

  task automatic t_daa();
    set_flags(8'h00);
    expect_op("R9 low digit", 4'd4, 8'h1B, 8'h00, 8'h21, 8'h00);
    set_flags(8'h02);
    expect_op("R9 ac", 4'd4, 8'h12, 8'h00, 8'h18, 8'h02);
    set_flags(8'h00);
    expect_op("R9 high digit", 4'd4, 8'hA5, 8'h00, 8'h05, 8'h01);
    set_flags(8'h01);
    expect_op("R9 c", 4'd4, 8'h23, 8'h00, 8'h83, 8'h01);
    set_flags(8'h00);
    expect_op("R9 both", 4'd4, 8'hAB, 8'h00, 8'h11, 8'h01);
    set_flags(8'h04);
    expect_op("R9 z kept", 4'd4, 8'h1B, 8'h00, 8'h21, 8'h04);
  endtask

  task automatic t_sysflags();
    set_flags(8'h05);
    cyc(0, 4'd15, 0, 0, 0, 0, 1, 0, 0);
    chk("R11 halt", "status", status, 8'h15);
    cyc(0, 4'd15, 0, 0, 0, 0, 0, 0, 1);
    chk("R12 timeout", "status", status, 8'h35);
    set_flags(8'hC0);
    chk("R10 write keeps sys", "status", status, 8'h30);
    set_flags(8'hFF);
    chk("R10 write all ones", "status", status, 8'h3F);
    cyc(1, 4'd0, 8'hFF, 8'h01, 1, 8'h00, 0, 0, 0);
    chk("R10 write vs add", "status", status, 8'h30);
    chk("R10 write vs add", "result", result, 8'h00);
    cyc(0, 4'd15, 0, 0, 0, 0, 0, 1, 0);
    chk("R11 clrwdt", "status", status, 8'h00);
    cyc(0, 4'd15, 0, 0, 0, 0, 1, 1, 0);
    chk("R11 clrwdt beats halt", "status", status, 8'h00);
    cyc(0, 4'd15, 0, 0, 0, 0, 0, 0, 1);
    chk("R12 timeout again", "status", status, 8'h20);
    cyc(0, 4'd15, 0, 0, 0, 0, 1, 0, 1);
    chk("R12 halt beats timeout", "status", status, 8'h10);
    cyc(0, 4'd15, 0, 0, 0, 0, 0, 1, 1);
    chk("R12 clrwdt beats timeout", "status", status, 8'h00);
  endtask

  task automatic t_hold();
    set_flags(8'h00);
    run_op(4'd0, 8'h12, 8'h34);
    cyc(0, 4'd0, 8'hFF, 8'h01, 0, 0, 0, 0, 0);
    chk("R13 disabled", "result", result, 8'h46);
    chk("R13 disabled", "status", status, 8'h00);
    run_op(4'd15, 8'hFF, 8'hFF);
    chk("R13 reserved code", "result", result, 8'h46);
    chk("R13 reserved code", "status", status, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_rotate();
    t_daa();
    t_sysflags();
    t_hold();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule